// File: doc/BRIEF.md
# Edge-Touch Centering Command Controller

This block steers a character image on a photosensor grid towards the centre before recognition begins. Four sensors along the grid border report which sides the image touches. From that 4-bit touch vector the controller picks one positioning command for a mechanical actuator: magnify, contract combined with a move, or shift by a full or a half cell. After each command it waits a programmable settle time so the actuator can finish, then samples the touch vector again.

The controller stops when the image spans one axis or both. It then reports which axis is centred. When only one axis is spanned, it also raises a one-cycle handover pulse so that a later combinational symmetry stage can finish the job. If the image disappears from the grid, the run is abandoned and the controller returns home. A new run needs a fresh start pulse.

States and transitions:
- HOME: the output is suppressed. `start_i` moves it to SAMPLE.
- SAMPLE lasts one cycle and has three exits:
  - If the image is lost, it goes to HOME with an abort pulse.
  - If the decoded command is a centred indication, it goes to DONE.
  - Otherwise it issues the command, loads the settle timer and goes to SETTLE.
- SETTLE: when the timer expires, it returns to SAMPLE.
- DONE holds the per-axis flags until the next run:
  - `start_i` clears the flags and goes to SAMPLE.
  - `init_i` forces HOME from any state.

Top module: `edge_center_ctrl`

## Requirements
- R1: After reset, or one cycle after `init_i`, the controller is in HOME. `cmd_code_o` is 0, `cmd_valid_o` is low and all centred flags are low. No command is issued until `start_i` is pulsed, whatever the edge inputs do.
- R2: The touch vector is {top, right, bottom, left} on bits 3..0. A vector of 0000 gives magnify (code 1). Left only gives full right (2). Right only gives full left (3). Bottom only gives full up (4). Top only gives full down (5).
- R3: Three-edge vectors give a contract-and-move command:
  - top+right+left gives contract-down (13);
  - right+bottom+left gives contract-up (12);
  - top+bottom+left gives contract-right (10);
  - top+right+bottom gives contract-left (11).
- R4: Two adjacent edges give a half-cell shift away from that corner:
  - top+right gives half down (7);
  - bottom+left gives half up (6);
  - top+left gives half right (8);
  - bottom+right gives half left (9).
- R5: `cmd_valid_o` is a one-cycle strobe, is never asserted with code 0, and fires only in the cycle after a SAMPLE state.
- R6: Successive command strobes of one run are exactly `settle_len_i`+2 cycles apart. An edge change made during the settle window is acted on only at the next sample.
- R7: Top+bottom only gives centred top-bottom (14) and raises `ctr_tb_o`. Left+right only gives centred right-left (15) and raises `ctr_rl_o`. In both cases `handover_o` pulses for one cycle together with the strobe.
- R8: All four edges give all-centred (16) and raise `ctr_all_o`. The per-axis flags stay low and there is no handover pulse. At most one of the three centred flags is high at any time.
- R9: After a centred indication, no further strobes occur and the flag holds until `start_i` or `init_i`. `start_i` clears the flag and starts a new sampling run.
- R10: If `lit_i` is low when the controller samples, `abort_o` pulses for one cycle and the controller returns to HOME with code 0 and flags clear. Afterwards only `start_i` resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous return to HOME |
| start_i | input | 1 | Begins a centering run |
| edge_i | input | 4 | Border touch vector {top, right, bottom, left} |
| lit_i | input | 1 | High while any grid cell sees the character |
| settle_len_i | input | CNT_W | Settle wait after each command, in cycles |
| cmd_code_o | output | 5 | Last command code; 0 when suppressed |
| cmd_valid_o | output | 1 | One-cycle strobe for a new command |
| ctr_tb_o | output | 1 | Centred between top and bottom only |
| ctr_rl_o | output | 1 | Centred between right and left only |
| ctr_all_o | output | 1 | Centred on both axes |
| handover_o | output | 1 | Pulse handing a partial result to the follow-on stage |
| abort_o | output | 1 | Pulse when the character was lost |

## Verification
A state register stuck in or skipping SETTLE shows up at the second strobe of a run: the strobe spacing departs from `settle_len_i`+2 within a few tens of cycles. A wrong exit from SAMPLE shows up at once as the wrong code, a missing or misplaced flag, or a stray handover pulse on the same strobe. A DONE or HOME state that fails to hold shows up as an unexpected strobe during the idle windows that follow a centred result or an abort.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int EDGE_W = 4;
    localparam int BIT_TOP = 3;
    localparam int BIT_RIGHT = 2;
    localparam int BIT_BOTTOM = 1;
    localparam int BIT_LEFT = 0;
    localparam int CODE_W = 5;

    typedef enum logic [CODE_W-1:0] {
        CMD_NOP      = 5'd0,
        CMD_MAG      = 5'd1,
        CMD_FULL_R   = 5'd2,
        CMD_FULL_L   = 5'd3,
        CMD_FULL_U   = 5'd4,
        CMD_FULL_D   = 5'd5,
        CMD_HALF_U   = 5'd6,
        CMD_HALF_D   = 5'd7,
        CMD_HALF_R   = 5'd8,
        CMD_HALF_L   = 5'd9,
        CMD_CON_R    = 5'd10,
        CMD_CON_L    = 5'd11,
        CMD_CON_U    = 5'd12,
        CMD_CON_D    = 5'd13,
        CMD_CTR_TB   = 5'd14,
        CMD_CTR_RL   = 5'd15,
        CMD_CTR_ALL  = 5'd16
    } cmd_e;

    typedef enum logic [1:0] {
        ST_HOME   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_SETTLE = 2'd2,
        ST_DONE   = 2'd3
    } state_e;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= len_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R6
    count_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import ecc_pkg::*;
(
    input  logic [EDGE_W-1:0] edges_i,
    output cmd_e              cmd_o,
    output logic              final_o
);
    always_comb begin
        cmd_o = CMD_NOP;
        unique case (edges_i)
            4'b0000: cmd_o = CMD_MAG;
            4'b0001: cmd_o = CMD_FULL_R;
            4'b0010: cmd_o = CMD_FULL_U;
            4'b0011: cmd_o = CMD_HALF_U;
            4'b0100: cmd_o = CMD_FULL_L;
            4'b0101: cmd_o = CMD_CTR_RL;
            4'b0110: cmd_o = CMD_HALF_L;
            4'b0111: cmd_o = CMD_CON_U;
            4'b1000: cmd_o = CMD_FULL_D;
            4'b1001: cmd_o = CMD_HALF_R;
            4'b1010: cmd_o = CMD_CTR_TB;
            4'b1011: cmd_o = CMD_CON_R;
            4'b1100: cmd_o = CMD_HALF_D;
            4'b1101: cmd_o = CMD_CON_D;
            4'b1110: cmd_o = CMD_CON_L;
            4'b1111: cmd_o = CMD_CTR_ALL;
            default: cmd_o = CMD_NOP;
        endcase
    end

    assign final_o = (cmd_o == CMD_CTR_TB) || (cmd_o == CMD_CTR_RL) ||
                     (cmd_o == CMD_CTR_ALL);

    // R7
    always_comb begin
        final_needs_pair_chk: assert (!final_o ||
            (edges_i[BIT_TOP] && edges_i[BIT_BOTTOM]) ||
            (edges_i[BIT_LEFT] && edges_i[BIT_RIGHT]));
    end
endmodule

// File: rtl/edge_center_ctrl.sv
module edge_center_ctrl
    import ecc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             start_i,
    input  logic [3:0]       edge_i,
    input  logic             lit_i,
    input  logic [CNT_W-1:0] settle_len_i,
    output logic [4:0]       cmd_code_o,
    output logic             cmd_valid_o,
    output logic             ctr_tb_o,
    output logic             ctr_rl_o,
    output logic             ctr_all_o,
    output logic             handover_o,
    output logic             abort_o
);
    localparam int SYNC_W = EDGE_W + 1;

    state_e              state_q, state_d;
    logic [SYNC_W-1:0]   sync_q;
    logic [EDGE_W-1:0]   edges_s;
    logic                lit_s;
    cmd_e                dec_cmd;
    logic                dec_final;
    logic                timer_load;
    logic                timer_expired;

    edge_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({lit_i, edge_i}),
        .q_o   (sync_q)
    );

    assign edges_s = sync_q[EDGE_W-1:0];
    assign lit_s   = sync_q[EDGE_W];

    cmd_decode i_decode (
        .edges_i (edges_s),
        .cmd_o   (dec_cmd),
        .final_o (dec_final)
    );

    assign timer_load = !init_i && (state_q == ST_SAMPLE) && lit_s && !dec_final;

    settle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (timer_load),
        .len_i     (settle_len_i),
        .expired_o (timer_expired)
    );

    always_comb begin
        state_d = state_q;
        if (init_i) begin
            state_d = ST_HOME;
        end else begin
            unique case (state_q)
                ST_HOME:   if (start_i) state_d = ST_SAMPLE;
                ST_SAMPLE: begin
                    if (!lit_s)         state_d = ST_HOME;
                    else if (dec_final) state_d = ST_DONE;
                    else                state_d = ST_SETTLE;
                end
                ST_SETTLE: if (timer_expired) state_d = ST_SAMPLE;
                ST_DONE:   if (start_i) state_d = ST_SAMPLE;
                default:   state_d = ST_HOME;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOME;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_code_o  <= CMD_NOP;
            cmd_valid_o <= 1'b0;
            ctr_tb_o    <= 1'b0;
            ctr_rl_o    <= 1'b0;
            ctr_all_o   <= 1'b0;
            handover_o  <= 1'b0;
            abort_o     <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            handover_o  <= 1'b0;
            abort_o     <= 1'b0;
            if (init_i) begin
                cmd_code_o <= CMD_NOP;
                ctr_tb_o   <= 1'b0;
                ctr_rl_o   <= 1'b0;
                ctr_all_o  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_SAMPLE: begin
                        if (!lit_s) begin
                            abort_o    <= 1'b1;
                            cmd_code_o <= CMD_NOP;
                            ctr_tb_o   <= 1'b0;
                            ctr_rl_o   <= 1'b0;
                            ctr_all_o  <= 1'b0;
                        end else begin
                            cmd_code_o  <= dec_cmd;
                            cmd_valid_o <= 1'b1;
                            if (dec_final) begin
                                ctr_tb_o   <= (dec_cmd == CMD_CTR_TB);
                                ctr_rl_o   <= (dec_cmd == CMD_CTR_RL);
                                ctr_all_o  <= (dec_cmd == CMD_CTR_ALL);
                                handover_o <= (dec_cmd != CMD_CTR_ALL);
                            end
                        end
                    end
                    ST_DONE: begin
                        if (start_i) begin
                            ctr_tb_o  <= 1'b0;
                            ctr_rl_o  <= 1'b0;
                            ctr_all_o <= 1'b0;
                        end
                    end
                    ST_HOME, ST_SETTLE: ;
                    default: ;
                endcase
            end
        end
    end

    // R1
    home_is_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOME) |-> (cmd_code_o == 5'd0 && !cmd_valid_o));

    // R5
    strobe_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> ($past(state_q) == ST_SAMPLE && cmd_code_o != 5'd0));

    // R5
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R6
    settle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !timer_expired && !init_i) |=> (state_q == ST_SETTLE));

    // R7
    handover_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handover_o |-> (cmd_valid_o && (ctr_tb_o ^ ctr_rl_o) && !ctr_all_o));

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctr_tb_o, ctr_rl_o, ctr_all_o}));

    // R9
    done_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DONE && state_q == ST_DONE) |-> !cmd_valid_o);

    // R10
    abort_goes_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (state_q == ST_HOME && cmd_code_o == 5'd0 && !ctr_all_o));
endmodule

// File: tb/test_edge_center_ctrl.sv
module test_edge_center_ctrl;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_i = 1'b0;
    logic             start_i = 1'b0;
    logic [3:0]       edge_i = 4'b0000;
    logic             lit_i = 1'b1;
    logic [CNT_W-1:0] settle_len_i = 8'd3;
    logic [4:0]       cmd_code_o;
    logic             cmd_valid_o;
    logic             ctr_tb_o, ctr_rl_o, ctr_all_o, handover_o, abort_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    edge_center_ctrl #(.CNT_W(CNT_W)) i_edge_center_ctrl (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .start_i(start_i),
        .edge_i(edge_i), .lit_i(lit_i), .settle_len_i(settle_len_i),
        .cmd_code_o(cmd_code_o), .cmd_valid_o(cmd_valid_o),
        .ctr_tb_o(ctr_tb_o), .ctr_rl_o(ctr_rl_o), .ctr_all_o(ctr_all_o),
        .handover_o(handover_o), .abort_o(abort_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_code(input logic [3:0] v);
        case (v)
            4'b0000: return 1;  4'b0001: return 2;  4'b0010: return 4;
            4'b0100: return 3;  4'b1000: return 5;
            4'b1101: return 13; 4'b0111: return 12; 4'b1011: return 10;
            4'b1110: return 11;
            4'b1100: return 7;  4'b0011: return 6;  4'b1001: return 8;
            4'b0110: return 9;
            4'b1010: return 14; 4'b0101: return 15; 4'b1111: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] v);
        if (v == 4'b1111) return "R8";
        if (v == 4'b1010 || v == 4'b0101) return "R7";
        if ($countones(v) == 3) return "R3";
        if ($countones(v) == 2) return "R4";
        return "R2";
    endfunction

    task automatic pulse_init();
        @(negedge clk) init_i = 1'b1;
        @(negedge clk) init_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_strobe(output int cycles);
        cycles = -1;
        for (int i = 1; i <= 600; i++) begin
            @(negedge clk);
            if (cmd_valid_o) begin
                cycles = i;
                break;
            end
        end
    endtask

    task automatic count_strobes(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmd_valid_o) seen++;
        end
    endtask

    task automatic begin_run(input logic [3:0] v, output int cycles);
        pulse_init();
        edge_i = v;
        lit_i  = 1'b1;
        repeat (4) @(negedge clk);
        pulse_start();
        wait_strobe(cycles);
    endtask

    task automatic t_reset();
        int seen;
        chk("R1", "code after reset", cmd_code_o, 0);
        chk("R1", "valid after reset", cmd_valid_o, 0);
        chk("R1", "flags after reset", {ctr_tb_o, ctr_rl_o, ctr_all_o}, 0);
        edge_i = 4'b0001;
        count_strobes(20, seen);
        chk("R1", "strobes without start", seen, 0);
    endtask

    task automatic t_decode_all();
        int c;
        for (int v = 0; v < 16; v++) begin
            settle_len_i = 8'd3;
            begin_run(v[3:0], c);
            chk(req_of(v[3:0]), $sformatf("code for edges %b", v[3:0]), cmd_code_o, exp_code(v[3:0]));
            chk(req_of(v[3:0]), "strobe seen", int'(c > 0), 1);
            chk(req_of(v[3:0]), "tb flag", ctr_tb_o, int'(v == 10));
            chk(req_of(v[3:0]), "rl flag", ctr_rl_o, int'(v == 5));
            chk(req_of(v[3:0]), "all flag", ctr_all_o, int'(v == 15));
            chk(req_of(v[3:0]), "handover", handover_o, int'(v == 10 || v == 5));
            @(negedge clk);
            chk("R5", "strobe width", cmd_valid_o, 0);
            chk("R7", "handover width", handover_o, 0);
        end
    endtask

    task automatic t_settle();
        int c;
        settle_len_i = 8'd10;
        begin_run(4'b0001, c);
        chk("R6", "first shift", cmd_code_o, 2);
        edge_i = 4'b0100;
        wait_strobe(c);
        chk("R6", "spacing len 10", c, 12);
        chk("R6", "code after settle", cmd_code_o, 3);
        settle_len_i = 8'd0;
        edge_i = 4'b0000;
        wait_strobe(c);
        chk("R6", "spacing len 10 again", c, 12);
        wait_strobe(c);
        chk("R6", "spacing len 0", c, 2);
        chk("R2", "magnify repeat", cmd_code_o, 1);
    endtask

    task automatic t_done_hold();
        int c, seen;
        settle_len_i = 8'd3;
        begin_run(4'b1010, c);
        chk("R7", "partial tb code", cmd_code_o, 14);
        edge_i = 4'b0001;
        count_strobes(30, seen);
        chk("R9", "no strobe in done", seen, 0);
        chk("R9", "tb flag held", ctr_tb_o, 1);
        pulse_start();
        chk("R9", "flag cleared by start", ctr_tb_o, 0);
        wait_strobe(c);
        chk("R9", "resample after start", cmd_code_o, 2);
        begin_run(4'b0101, c);
        chk("R7", "partial rl code", cmd_code_o, 15);
        pulse_init();
        chk("R1", "init clears rl flag", ctr_rl_o, 0);
        chk("R1", "init clears code", cmd_code_o, 0);
    endtask

    task automatic t_abort();
        int c, seen;
        bit got;
        settle_len_i = 8'd10;
        begin_run(4'b1000, c);
        chk("R10", "shift before loss", cmd_code_o, 5);
        lit_i = 1'b0;
        got = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (abort_o) begin got = 1'b1; break; end
        end
        chk("R10", "abort pulse", got, 1);
        chk("R10", "code after abort", cmd_code_o, 0);
        @(negedge clk);
        chk("R10", "abort width", abort_o, 0);
        lit_i = 1'b1;
        count_strobes(30, seen);
        chk("R10", "no strobe after abort", seen, 0);
        pulse_start();
        wait_strobe(c);
        chk("R10", "resume on start", cmd_code_o, 5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode_all();
        t_settle();
        t_done_hold();
        t_abort();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule